// File: doc/BRIEF.md
# Packet Field Slice Extractor

This block picks a small set of 16-bit fields out of a received frame while the frame streams past, one byte per accepted beat. Each of the nine slots has a configuration byte naming an anchor point (the end of the link-layer header or the end of the network-layer header) and a distance from that anchor counted in 2-byte words. A header parser ahead of this block flags, on the byte stream itself, the first byte after each of those two headers; this block does no parsing. When the last byte of the frame has been taken, the block presents every captured field with a per-slot valid bitmap and a one-cycle done pulse. A classifier downstream then compares those fields against its rules.

A typical layout for TCP or UDP over IPv4 uses link-layer words 6 to 9 for the two addresses, as 16-bit halves, and network-layer words 0 and 1 for the two port numbers. The unused slots stay at zero. Software fills the active slots from slot 0 upward, so the set valid bits sit at the bottom of the bitmap. Configuration is written through a plain write port. Each slot takes a snapshot of it when a frame starts.

Top module: `fx_slice_extract`

## Requirements
- R1: Configuration byte layout: bits [6:5] hold the anchor code and bits [4:0] the word offset. Anchor code 01 means the link-layer end, code 10 the network-layer end, and bit 7 is ignored. A slot whose anchor code is 00 or 11 (so also an all-zero byte) is unused: its valid bit and field stay 0.
- R2: Byte position 0 is the byte that carries the matching marker (`in_l2_mark` or `in_l3_mark`). A slot with word offset k captures byte positions 2k and 2k+1, the first of them in field bits [15:8]. Field i appears on `fields_o[16*i+15 : 16*i]`.
- R3: `valid_o[i]` is set only when both bytes of slot i arrived no later than the end-of-frame beat. Otherwise it is 0 and the field reads 0.
- R4: The configuration used for a frame is the one held in the registers at its start-of-frame beat. A write during the frame, including one in the start-of-frame cycle itself, first takes effect on the next frame.
- R5: `done_o` is high for exactly the one cycle after the end-of-frame beat. `valid_o` and `fields_o` change in that same cycle only, and hold their values until the next done pulse.
- R6: Beats with `in_valid` low are ignored, and so are beats that lie outside a frame (after an end of frame and before the next start of frame), including any end flag or marker they carry.
- R7: A slot anchored to a boundary whose marker does not appear in the frame reports valid 0 and field 0.
- R8: After reset, `done_o`, `valid_o` and `fields_o` are 0 and every configuration byte is 0, so every slot is unused.
- R9: A marker may arrive on the start-of-frame beat, and a frame may be a single beat with both start and end flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Slot number to write |
| cfg_data | input | 8 | Configuration byte |
| in_valid | input | 1 | Beat qualifier for the byte stream |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_l2_mark | input | 1 | This byte is the first after the link-layer header |
| in_l3_mark | input | 1 | This byte is the first after the network-layer header |
| done_o | output | 1 | One-cycle pulse: the results for a frame are ready |
| valid_o | output | NUM_SLOTS (9) | Per-slot field valid bitmap |
| fields_o | output | 16*NUM_SLOTS (144) | Captured fields, slot 0 in the low bits |

## Verification
The hardest cases to reach are those where the capture window straddles the frame end: a field whose high byte lands on the last beat while its low byte would have followed, and a slot whose anchor marker never came. Other hard cases are a configuration write that falls inside a frame, in particular one that shares a cycle with the start-of-frame beat. The stimulus builds frames of random length with random marker positions, random idle gaps and occasional mid-frame writes. Directed frames are also cut to end exactly one byte short of, or right at, a field's second byte, and single-beat and two-beat frames carry their marker on the first byte.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int CFG_W   = 8;
  localparam int OFF_W   = 5;
  localparam int FIELD_W = 16;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    ANCHOR_NONE = 2'b00,
    ANCHOR_L2   = 2'b01,
    ANCHOR_L3   = 2'b10,
    ANCHOR_RSV  = 2'b11
  } anchor_e;

  function automatic anchor_e cfg_anchor(input logic [CFG_W-1:0] c);
    return anchor_e'(c[6:5]);
  endfunction

  function automatic logic [OFF_W-1:0] cfg_offset(input logic [CFG_W-1:0] c);
    return c[OFF_W-1:0];
  endfunction

  function automatic logic cfg_in_use(input logic [CFG_W-1:0] c);
    return (cfg_anchor(c) == ANCHOR_L2) || (cfg_anchor(c) == ANCHOR_L3);
  endfunction
endpackage

// File: rtl/fx_cfg_bank.sv
module fx_cfg_bank
  import fx_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  parameter int ADDR_W    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [CFG_W-1:0]                    wdata,
  input  logic                                sof_beat,
  output logic [NUM_SLOTS-1:0][CFG_W-1:0]     cfg_now
);
  logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg_q;
  logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg_snap;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i]    <= '0;
        cfg_snap[i] <= '0;
      end else begin
        if (we && addr == ADDR_W'(i)) cfg_q[i] <= wdata;
        if (sof_beat)                 cfg_snap[i] <= cfg_q[i];
      end
    end
    // the start beat already uses the register value it snapshots
    assign cfg_now[i] = sof_beat ? cfg_q[i] : cfg_snap[i];
  end
endmodule

// File: rtl/fx_pos_track.sv
module fx_pos_track #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             mark,
  output logic             here_ok,
  output logic [POS_W-1:0] here_pos
);
  logic             seen_q;
  logic [POS_W-1:0] next_q;
  logic             mark_b;

  assign mark_b   = beat && mark;
  assign here_ok  = mark_b || (seen_q && !sof);
  assign here_pos = mark_b ? '0 : next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      next_q <= '0;
    end else if (beat) begin
      if (mark_b) begin
        seen_q <= 1'b1;
        next_q <= POS_W'(1);
      end else if (sof) begin
        seen_q <= 1'b0;
      end else if (seen_q && next_q != '1) begin
        next_q <= next_q + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/fx_slot.sv
module fx_slot
  import fx_pkg::*;
#(
  parameter int POS_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               sof,
  input  logic [CFG_W-1:0]   cfg,
  input  logic [BYTE_W-1:0]  data,
  input  logic               l2_ok,
  input  logic [POS_W-1:0]   l2_pos,
  input  logic               l3_ok,
  input  logic [POS_W-1:0]   l3_pos,
  output logic               active,
  output logic               hit_hi,
  output logic               hit_lo,
  output logic               nxt_valid,
  output logic [FIELD_W-1:0] nxt_field
);
  function automatic logic [POS_W-1:0] byte_at(input logic [OFF_W-1:0] word,
                                              input logic second);
    return {{(POS_W-OFF_W-1){1'b0}}, word, second};
  endfunction

  logic              unused_cfg_top;
  anchor_e           anc;
  logic              sel_ok;
  logic [POS_W-1:0]  sel_pos;
  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic              ghi_q, glo_q, ghi_d, glo_d;
  logic              sof_b;

  assign unused_cfg_top = cfg[CFG_W-1];
  assign anc     = cfg_anchor(cfg);
  assign active  = cfg_in_use(cfg);
  assign sel_ok  = (anc == ANCHOR_L2) ? l2_ok  : l3_ok;
  assign sel_pos = (anc == ANCHOR_L2) ? l2_pos : l3_pos;
  assign sof_b   = beat && sof;

  assign hit_hi = beat && active && sel_ok && sel_pos == byte_at(cfg_offset(cfg), 1'b0);
  assign hit_lo = beat && active && sel_ok && sel_pos == byte_at(cfg_offset(cfg), 1'b1);

  always_comb begin
    hi_d  = sof_b ? '0 : hi_q;
    lo_d  = sof_b ? '0 : lo_q;
    ghi_d = ghi_q && !sof_b;
    glo_d = glo_q && !sof_b;
    if (hit_hi) begin
      hi_d  = data;
      ghi_d = 1'b1;
    end
    if (hit_lo) begin
      lo_d  = data;
      glo_d = 1'b1;
    end
  end

  assign nxt_valid = ghi_d && glo_d;
  assign nxt_field = nxt_valid ? {hi_d, lo_d} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ghi_q <= 1'b0;
      glo_q <= 1'b0;
    end else if (beat) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      ghi_q <= ghi_d;
      glo_q <= glo_d;
    end
  end
endmodule

// File: rtl/fx_slice_extract.sv
module fx_slice_extract
  import fx_pkg::*;
#(
  parameter  int NUM_SLOTS = 9,
  localparam int ADDR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic [7:0]                   cfg_data,
  input  logic                         in_valid,
  input  logic [7:0]                   in_data,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic                         in_l2_mark,
  input  logic                         in_l3_mark,
  output logic                         done_o,
  output logic [NUM_SLOTS-1:0]         valid_o,
  output logic [16*NUM_SLOTS-1:0]      fields_o
);
  // saturating position must exceed the farthest reachable byte
  localparam int POS_W = OFF_W + 2;

  logic                            in_frame;
  logic                            beat;
  logic                            sof_beat;
  logic                            frame_end;
  logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg_now;
  logic                            l2_ok, l3_ok;
  logic [POS_W-1:0]                l2_pos, l3_pos;
  logic [NUM_SLOTS-1:0]            act_now;
  logic [NUM_SLOTS-1:0]            hit_hi, hit_lo;
  logic [NUM_SLOTS-1:0]            nxt_valid;
  logic [FIELD_W*NUM_SLOTS-1:0]    nxt_fields;

  assign beat      = in_valid && (in_sof || in_frame);
  assign sof_beat  = beat && in_sof;
  assign frame_end = beat && in_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) in_frame <= 1'b0;
    else if (beat) in_frame <= !in_eof;
  end

  fx_cfg_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_data),
    .sof_beat(sof_beat), .cfg_now(cfg_now)
  );

  fx_pos_track #(.POS_W(POS_W)) u_l2 (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .mark(in_l2_mark),
    .here_ok(l2_ok), .here_pos(l2_pos)
  );

  fx_pos_track #(.POS_W(POS_W)) u_l3 (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .mark(in_l3_mark),
    .here_ok(l3_ok), .here_pos(l3_pos)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    fx_slot #(.POS_W(POS_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .cfg(cfg_now[i]),
      .data(in_data), .l2_ok(l2_ok), .l2_pos(l2_pos), .l3_ok(l3_ok), .l3_pos(l3_pos),
      .active(act_now[i]), .hit_hi(hit_hi[i]), .hit_lo(hit_lo[i]),
      .nxt_valid(nxt_valid[i]), .nxt_field(nxt_fields[i*FIELD_W +: FIELD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      valid_o  <= '0;
      fields_o <= '0;
    end else begin
      done_o <= frame_end;
      if (frame_end) begin
        valid_o  <= nxt_valid;
        fields_o <= nxt_fields;
      end
    end
  end
endmodule

// File: rtl/fx_slice_extract_chk.sv
module fx_slice_extract_chk #(
  parameter int NUM_SLOTS = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_sof,
  input logic                        in_frame,
  input logic                        frame_end,
  input logic [NUM_SLOTS-1:0]        act_now,
  input logic [NUM_SLOTS-1:0]        hit_hi,
  input logic [NUM_SLOTS-1:0][7:0]   cfg_now,
  input logic                        done_o,
  input logic [NUM_SLOTS-1:0]        valid_o,
  input logic [16*NUM_SLOTS-1:0]     fields_o
);
  AST_DONE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> done_o); // R5
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(frame_end)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> ($stable(valid_o) && $stable(fields_o))); // R5
  AST_VALID_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ((valid_o & ~$past(act_now)) == '0)); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (in_frame && !(in_valid && in_sof)) |-> $stable(cfg_now)); // R4
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!in_frame && !(in_valid && in_sof)) |=> !done_o); // R6
  AST_HIT_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n) (hit_hi & ~act_now) == '0); // R1

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_zero
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !valid_o[i] |-> fields_o[16*i +: 16] == 16'h0); // R3
  end
endmodule

bind fx_slice_extract fx_slice_extract_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_frame(in_frame),
  .frame_end(frame_end), .act_now(act_now), .hit_hi(hit_hi), .cfg_now(cfg_now),
  .done_o(done_o), .valid_o(valid_o), .fields_o(fields_o)
);

// File: tb/sim_fx_slice_extract.sv
module sim_fx_slice_extract;
  localparam int NS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_sof = 1'b0, in_eof = 1'b0, in_l2_mark = 1'b0, in_l3_mark = 1'b0;
  logic done_o;
  logic [NS-1:0] valid_o;
  logic [16*NS-1:0] fields_o;

  always #5 clk = ~clk;

  fx_slice_extract #(.NUM_SLOTS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_l2_mark(in_l2_mark), .in_l3_mark(in_l3_mark),
    .done_o(done_o), .valid_o(valid_o), .fields_o(fields_o)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] fb [128];
  int flen, m2, m3;
  logic [7:0] cfg_m [NS];
  logic [7:0] snap [NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // expected slot result from the configuration rules
  function automatic void model_slot(input logic [7:0] c, output bit v, output logic [15:0] f);
    int base, idx;
    v = 0; f = '0;
    if (c[6:5] == 2'b01) base = m2;
    else if (c[6:5] == 2'b10) base = m3;
    else return;
    if (base < 0) return;
    idx = base + 2 * int'(c[4:0]);
    if (idx + 1 < flen) begin
      v = 1;
      f = {fb[idx], fb[idx+1]};
    end
  endfunction

  task automatic idle_drive();
    in_valid = 0; in_sof = 0; in_eof = 0; in_l2_mark = 0; in_l3_mark = 0; cfg_we = 0;
    in_data = 8'($urandom);
  endtask

  task automatic wr_cfg(input int a, input logic [7:0] v);
    @(negedge clk);
    idle_drive();
    cfg_we = 1; cfg_addr = 4'(a); cfg_data = v;
    cfg_m[a] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_frame(input int gap_pct, input int wr_at, input int wr_addr,
                           input logic [7:0] wr_val, input string req);
    logic [NS-1:0] ev;
    logic [16*NS-1:0] ef;
    logic [NS-1:0] hv;
    logic [16*NS-1:0] hf;
    for (int s = 0; s < NS; s++) snap[s] = cfg_m[s];
    for (int i = 0; i < flen; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        @(negedge clk);
        idle_drive();
        in_eof = 1'($urandom); in_l2_mark = 1'($urandom);
      end
      @(negedge clk);
      idle_drive();
      in_valid = 1; in_data = fb[i];
      in_sof = (i == 0); in_eof = (i == flen - 1);
      in_l2_mark = (i == m2); in_l3_mark = (i == m3);
      if (i == wr_at) begin
        cfg_we = 1; cfg_addr = 4'(wr_addr); cfg_data = wr_val;
        cfg_m[wr_addr] = wr_val;
      end
    end
    @(negedge clk);
    idle_drive();
    for (int s = 0; s < NS; s++) begin
      bit v; logic [15:0] f;
      model_slot(snap[s], v, f);
      ev[s] = v; ef[16*s +: 16] = f;
    end
    chk(done_o == 1'b1, "R5", {req, " done pulse"}, 144'(done_o), 144'(1));
    chk(valid_o == ev, "R3", {req, " valid map"}, 144'(valid_o), 144'(ev));
    chk(fields_o == ef, "R2", {req, " fields"}, fields_o, ef);
    hv = valid_o; hf = fields_o;
    @(negedge clk);
    chk(done_o == 1'b0 && valid_o == hv && fields_o == hf, "R5", {req, " hold after pulse"},
        {fields_o[134:0], done_o, valid_o}, {hf[134:0], 1'b0, hv});
  endtask

  task automatic fill(input int len, input int a2, input int a3);
    flen = len; m2 = a2; m3 = a3;
    for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
  endtask

  initial begin
    #1_500_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) cfg_m[s] = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 0 && valid_o == '0 && fields_o == '0, "R8", "reset outputs",
        {fields_o[134:0], done_o, valid_o}, '0);
    rst_n = 1;

    // R8: no configuration written -> all slots unused
    fill(30, 2, 10);
    run_frame(0, -1, 0, 0, "R8 unconfigured");

    // R2: IPv4 address/port layout
    for (int s = 0; s < 4; s++) wr_cfg(s, 8'h20 | 8'(6 + s));
    wr_cfg(4, 8'h40); wr_cfg(5, 8'h41);
    fill(40, 14, 34);
    run_frame(0, -1, 0, 0, "R2 ip4 layout");
    chk(valid_o == 9'h03f, "R2", "ip4 low six valid", 144'(valid_o), 144'h03f);
    chk(fields_o[15:0] == {fb[26], fb[27]}, "R2", "first src half", 144'(fields_o[15:0]),
        144'({fb[26], fb[27]}));

    // R3: frame ends between the bytes of slot 5
    fill(37, 14, 34);
    run_frame(20, -1, 0, 0, "R3 truncated");
    chk(valid_o[5] == 0 && valid_o[4] == 1, "R3", "cut slot", 144'(valid_o), 144'h1f);
    fill(38, 14, 34);
    run_frame(0, -1, 0, 0, "R3 exact end");

    // R7: network-layer marker missing
    fill(60, 14, -1);
    run_frame(10, -1, 0, 0, "R7 no l3 mark");
    chk(valid_o[5:4] == 2'b00, "R7", "l3 slots clear", 144'(valid_o), 144'h0f);

    // R1: bit 7 ignored, code 11 unused
    wr_cfg(0, 8'hA1); wr_cfg(1, 8'h61); wr_cfg(2, 8'hC3);
    fill(50, 5, 20);
    run_frame(0, -1, 0, 0, "R1 codes");
    chk(valid_o[1] == 0 && valid_o[0] == 1 && valid_o[2] == 1, "R1", "code handling",
        144'(valid_o[2:0]), 144'(3'b101));

    // R9: markers on the start beat, tiny frames
    for (int s = 0; s < NS; s++) wr_cfg(s, s == 0 ? 8'h20 : (s == 1 ? 8'h40 : 8'h00));
    fill(1, 0, 0);
    run_frame(0, -1, 0, 0, "R9 one beat");
    fill(2, 0, 0);
    run_frame(0, -1, 0, 0, "R9 two beats");
    chk(valid_o[1:0] == 2'b11, "R9", "two beat valid", 144'(valid_o), 144'h3);

    // R4: writes inside the frame and in the start cycle
    fill(40, 3, 12);
    run_frame(0, 6, 0, 8'h22, "R4 mid write");
    fill(40, 3, 12);
    run_frame(0, 0, 1, 8'h45, "R4 sof write");
    fill(40, 3, 12);
    run_frame(0, -1, 0, 0, "R4 next frame");
    chk(fields_o[15:0] == {fb[7], fb[8]}, "R4", "new offset used", 144'(fields_o[15:0]),
        144'({fb[7], fb[8]}));

    // R6: junk beats outside any frame
    begin
      logic [NS-1:0] hv;
      logic [16*NS-1:0] hf;
      hv = valid_o; hf = fields_o;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        idle_drive();
        in_valid = 1; in_eof = 1'($urandom); in_l2_mark = 1'($urandom);
        in_l3_mark = 1'($urandom);
        @(negedge clk);
        idle_drive();
        chk(done_o == 0 && valid_o == hv && fields_o == hf, "R6", "beat outside frame",
            {fields_o[134:0], done_o, valid_o}, {hf[134:0], 1'b0, hv});
      end
    end

    // random frames
    for (int n = 0; n < 70; n++) begin
      int len, a2, a3, wa;
      for (int s = 0; s < NS; s++)
        if ($urandom % 3 == 0) wr_cfg(s, ($urandom % 4 == 0) ? 8'h00 : 8'($urandom));
      len = 1 + int'($urandom % 100);
      a2 = ($urandom % 10 == 0) ? -1 : int'($urandom % len);
      if ($urandom % 10 == 0) a3 = -1;
      else if (a2 < 0) a3 = int'($urandom % len);
      else a3 = a2 + int'($urandom % (len - a2));
      wa = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      fill(len, a2, a3);
      run_frame((n % 2) * 25, wa, int'($urandom % NS), 8'($urandom), "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule